// File: doc/BRIEF.md
# Dual-Issue Warp Instruction Scheduler

This block is the per-cycle issue stage of one warp scheduler. It owns a fixed set of warp slots. Each slot shows whether it holds a live warp, whether the scoreboard has cleared that warp to issue, and the next one or two decoded instructions of the warp. Each instruction is tagged with the engine that executes it. The second instruction also carries a flag that says it depends on the first. The block looks only at its own slots and picks at most one warp per cycle. It issues that warp's first instruction and, when the pairing rules allow, the second one in the same cycle. It raises one strobe for each engine that accepts an instruction.

Selection is round-robin. Starting from the slot after the last warp that issued, the first eligible slot wins. A warp that stalls therefore costs no cycle as long as any other warp it owns is eligible. The block tracks per-engine initiation intervals with countdown counters. The special-function and load/store engines take a new instruction at most once every four cycles. The ALU and branch engines take one every cycle. A warp whose first instruction targets a busy engine is not eligible. The slot owner pops one instruction on `issue_vld_o` and two on `pair_o`. A second instruction therefore never leaves ahead of the first.

Top module: `warp_issue_sched`

## Requirements
- R1: When `issue_vld_o` is high, `issue_warp_o` names a slot whose `slot_valid_i` and `slot_ready_i` bits are both high. No other slot is ever issued.
- R2: A slot is eligible when it is valid, ready, and its first instruction's engine is free. The issued warp is the first eligible slot found by searching upward, with wrap-around, from the slot after the last issued warp (slot 0 after reset). An issue happens in every cycle in which any slot is eligible.
- R3: When no slot is eligible, `issue_vld_o`, `pair_o` and `eng_fire_o` are all zero.
- R4: Engine codes are 0 ALU, 1 special-function, 2 load/store, 3 branch. `eng_fire_o[e]` is high exactly when an issued instruction in that cycle targets engine `e`. `eng_a_o` is the code of the first instruction. `eng_b_o` is the code of the second instruction when paired and 0 otherwise.
- R5: `pair_o` is high only if the selected slot has `op1_vld_i` high, `op1_dep_i` low, a second engine different from the first, and a free second engine. When all of these hold and single-issue mode is off, `pair_o` is high.
- R6: With default parameters, the special-function and load/store engines fire at most once in any 4 consecutive cycles. The ALU and branch engines may fire in every cycle.
- R7: An engine that fired within its initiation interval blocks both a first and a second instruction. A slot whose first instruction targets it is skipped in favour of the next eligible slot.
- R8: With `SINGLE_ISSUE` set to 1, `pair_o` is always low and only one engine fires per cycle.
- R9: `pair_o` is never high without `issue_vld_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| slot_valid_i | input | N_WARPS | Slot holds a live warp |
| slot_ready_i | input | N_WARPS | Scoreboard clears the warp to issue |
| op0_eng_i | input | 2*N_WARPS | Engine code of each slot's first instruction |
| op1_vld_i | input | N_WARPS | Slot presents a second instruction |
| op1_eng_i | input | 2*N_WARPS | Engine code of each slot's second instruction |
| op1_dep_i | input | N_WARPS | Second instruction depends on the first |
| issue_vld_o | output | 1 | First instruction of the selected warp issues |
| issue_warp_o | output | $clog2(N_WARPS) | Index of the selected warp |
| pair_o | output | 1 | Second instruction issues in the same cycle |
| eng_a_o | output | 2 | Engine code of the first issued instruction |
| eng_b_o | output | 2 | Engine code of the second issued instruction, or 0 |
| eng_fire_o | output | 4 | Per-engine accept strobes |

## Verification
The bound checker checks these properties on every cycle:
- issue only from valid, ready slots;
- silence when no slot is valid and ready;
- pairing only across distinct engines and only for an independent, present second instruction;
- no second instruction without a first;
- a strobe count that matches the issue count;
- a gap counter on each engine against its initiation interval.

Some behaviours only the bench's scenarios can show. These are the exact round-robin order, the absence of bubbles when a ready warp exists behind a busy engine, and a pair that must happen but is withheld. The bench shows them by running a pseudo-random sweep of slot patterns through a four-slot instance and a single-issue twin, and comparing every output against an arithmetic model of pointer and countdowns.

// File: rtl/wis_pkg.sv
package wis_pkg;
  localparam int N_ENG = 4;
  typedef enum logic [1:0] {
    ENG_ALU  = 2'd0,
    ENG_SFU  = 2'd1,
    ENG_LDST = 2'd2,
    ENG_BR   = 2'd3
  } engine_e;
endpackage

// File: rtl/wis_rr_pick.sv
module wis_rr_pick #(
  parameter int N = 16,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] req_i,
  input  logic [W-1:0] ptr_i,
  output logic         gnt_o,
  output logic [W-1:0] sel_o
);
  always_comb begin
    gnt_o = 1'b0;
    sel_o = '0;
    for (int i = 0; i < N; i++) begin
      int idx;
      idx = int'(ptr_i) + i;
      if (idx >= N) idx = idx - N;
      if (!gnt_o && req_i[idx]) begin
        gnt_o = 1'b1;
        sel_o = W'(idx);
      end
    end
  end
endmodule

// File: rtl/wis_eng_timer.sv
module wis_eng_timer
  import wis_pkg::*;
#(
  parameter int ALU_II  = 1,
  parameter int SFU_II  = 4,
  parameter int LDST_II = 4,
  parameter int BR_II   = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_ENG-1:0] fire_i,
  output logic [N_ENG-1:0] busy_o
);
  localparam int MAX_II = (ALU_II > SFU_II ? ALU_II : SFU_II) > (LDST_II > BR_II ? LDST_II : BR_II)
                        ? (ALU_II > SFU_II ? ALU_II : SFU_II) : (LDST_II > BR_II ? LDST_II : BR_II);
  localparam int CW = (MAX_II > 1) ? $clog2(MAX_II) : 1;

  for (genvar e = 0; e < N_ENG; e++) begin : g_eng
    localparam int II = (e == 0) ? ALU_II : (e == 1) ? SFU_II : (e == 2) ? LDST_II : BR_II;
    logic [CW-1:0] cnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)               cnt_q <= '0;
      else if (fire_i[e])        cnt_q <= CW'(II - 1);
      else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
    end
    assign busy_o[e] = (cnt_q != '0);
  end
endmodule

// File: rtl/wis_pair_chk.sv
module wis_pair_chk
  import wis_pkg::*;
#(
  parameter bit SINGLE_ISSUE = 1'b0
) (
  input  logic             gnt_i,
  input  logic [1:0]       eng_a_i,
  input  logic             b_vld_i,
  input  logic [1:0]       eng_b_i,
  input  logic             b_dep_i,
  input  logic [N_ENG-1:0] busy_i,
  output logic             pair_o
);
  if (SINGLE_ISSUE) begin : g_single
    logic unused;
    assign unused = ^{gnt_i, eng_a_i, b_vld_i, eng_b_i, b_dep_i, busy_i};
    assign pair_o = 1'b0;
  end else begin : g_dual
    assign pair_o = gnt_i && b_vld_i && !b_dep_i
                  && (eng_b_i != eng_a_i) && !busy_i[eng_b_i];
  end
endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
  import wis_pkg::*;
#(
  parameter int N_WARPS      = 16,
  parameter bit SINGLE_ISSUE = 1'b0,
  parameter int ALU_II       = 1,
  parameter int SFU_II       = 4,
  parameter int LDST_II      = 4,
  parameter int BR_II        = 1,
  localparam int W = (N_WARPS > 1) ? $clog2(N_WARPS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N_WARPS-1:0]   slot_valid_i,
  input  logic [N_WARPS-1:0]   slot_ready_i,
  input  logic [2*N_WARPS-1:0] op0_eng_i,
  input  logic [N_WARPS-1:0]   op1_vld_i,
  input  logic [2*N_WARPS-1:0] op1_eng_i,
  input  logic [N_WARPS-1:0]   op1_dep_i,
  output logic                 issue_vld_o,
  output logic [W-1:0]         issue_warp_o,
  output logic                 pair_o,
  output logic [1:0]           eng_a_o,
  output logic [1:0]           eng_b_o,
  output logic [3:0]           eng_fire_o
);
  logic [N_ENG-1:0] busy;
  logic [N_WARPS-1:0] elig;
  logic [W-1:0] ptr_q, sel;
  logic gnt, pair;
  logic [1:0] a_eng, b_eng;

  for (genvar w = 0; w < N_WARPS; w++) begin : g_elig
    assign elig[w] = slot_valid_i[w] && slot_ready_i[w] && !busy[op0_eng_i[2*w +: 2]];
  end

  wis_rr_pick #(.N(N_WARPS)) u_pick (
    .req_i (elig),
    .ptr_i (ptr_q),
    .gnt_o (gnt),
    .sel_o (sel)
  );

  assign a_eng = op0_eng_i[2*sel +: 2];
  assign b_eng = op1_eng_i[2*sel +: 2];

  wis_pair_chk #(.SINGLE_ISSUE(SINGLE_ISSUE)) u_pair (
    .gnt_i   (gnt),
    .eng_a_i (a_eng),
    .b_vld_i (op1_vld_i[sel]),
    .eng_b_i (b_eng),
    .b_dep_i (op1_dep_i[sel]),
    .busy_i  (busy),
    .pair_o  (pair)
  );

  always_comb begin
    eng_fire_o = '0;
    if (gnt)  eng_fire_o[a_eng] = 1'b1;
    if (pair) eng_fire_o[b_eng] = 1'b1;
  end

  wis_eng_timer #(
    .ALU_II(ALU_II), .SFU_II(SFU_II), .LDST_II(LDST_II), .BR_II(BR_II)
  ) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (eng_fire_o),
    .busy_o (busy)
  );

  // pointer moves just past the last issued warp
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  ptr_q <= '0;
    else if (gnt) ptr_q <= (int'(sel) == N_WARPS - 1) ? '0 : sel + 1'b1;
  end

  assign issue_vld_o  = gnt;
  assign issue_warp_o = sel;
  assign pair_o       = pair;
  assign eng_a_o      = a_eng;
  assign eng_b_o      = pair ? b_eng : 2'd0;
endmodule

// File: rtl/warp_issue_sched_chk.sv
module warp_issue_sched_chk #(
  parameter int N_WARPS      = 16,
  parameter bit SINGLE_ISSUE = 1'b0,
  parameter int ALU_II       = 1,
  parameter int SFU_II       = 4,
  parameter int LDST_II      = 4,
  parameter int BR_II        = 1,
  localparam int W = (N_WARPS > 1) ? $clog2(N_WARPS) : 1
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [N_WARPS-1:0]   slot_valid_i,
  input logic [N_WARPS-1:0]   slot_ready_i,
  input logic [2*N_WARPS-1:0] op1_eng_i,
  input logic [N_WARPS-1:0]   op1_vld_i,
  input logic [N_WARPS-1:0]   op1_dep_i,
  input logic                 issue_vld_o,
  input logic [W-1:0]         issue_warp_o,
  input logic                 pair_o,
  input logic [1:0]           eng_a_o,
  input logic [1:0]           eng_b_o,
  input logic [3:0]           eng_fire_o
);
  AST_OWN_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_vld_o |-> (slot_valid_i[issue_warp_o] && slot_ready_i[issue_warp_o])); // R1

  AST_IDLE_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((slot_valid_i & slot_ready_i) == '0) |-> (!issue_vld_o && !pair_o && eng_fire_o == 4'd0)); // R3

  AST_FIRE_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(eng_fire_o) == (32'(issue_vld_o) + 32'(pair_o))); // R4

  AST_FIRE_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_vld_o |-> eng_fire_o[eng_a_o]); // R4

  AST_PAIR_DISTINCT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_o |-> (eng_a_o != eng_b_o)); // R5

  AST_PAIR_INDEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_o |-> (op1_vld_i[issue_warp_o] && !op1_dep_i[issue_warp_o]
                && op1_eng_i[2*issue_warp_o +: 2] == eng_b_o)); // R5

  AST_SINGLE_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    SINGLE_ISSUE |-> !pair_o); // R8

  AST_PAIR_NEEDS_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_o |-> issue_vld_o); // R9

  // gap counters: cycles since each engine last fired
  for (genvar e = 0; e < 4; e++) begin : g_gap
    localparam int II = (e == 0) ? ALU_II : (e == 1) ? SFU_II : (e == 2) ? LDST_II : BR_II;
    logic [7:0] gap_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)               gap_q <= 8'hff;
      else if (eng_fire_o[e])    gap_q <= 8'd0;
      else if (gap_q != 8'hff)   gap_q <= gap_q + 8'd1;
    end
    AST_ENG_INTERVAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      eng_fire_o[e] |-> (32'(gap_q) >= II - 1)); // R6 R7
  end
endmodule

bind warp_issue_sched warp_issue_sched_chk #(
  .N_WARPS(N_WARPS), .SINGLE_ISSUE(SINGLE_ISSUE),
  .ALU_II(ALU_II), .SFU_II(SFU_II), .LDST_II(LDST_II), .BR_II(BR_II)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .slot_valid_i(slot_valid_i), .slot_ready_i(slot_ready_i),
  .op1_eng_i(op1_eng_i), .op1_vld_i(op1_vld_i), .op1_dep_i(op1_dep_i),
  .issue_vld_o(issue_vld_o), .issue_warp_o(issue_warp_o), .pair_o(pair_o),
  .eng_a_o(eng_a_o), .eng_b_o(eng_b_o), .eng_fire_o(eng_fire_o)
);

// File: tb/warp_issue_sched_test.sv
module warp_issue_sched_test;
  localparam int N = 4;
  localparam int W = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [N-1:0]   v, r, b_vld, b_dep;
  logic [2*N-1:0] a_e, b_e;

  logic         iv [2];
  logic [W-1:0] iw [2];
  logic         pr [2];
  logic [1:0]   ea [2], eb [2];
  logic [3:0]   ef [2];

  warp_issue_sched #(.N_WARPS(N), .SINGLE_ISSUE(1'b0)) uut (
    .clk_i(clk), .rst_ni(rst_n), .slot_valid_i(v), .slot_ready_i(r),
    .op0_eng_i(a_e), .op1_vld_i(b_vld), .op1_eng_i(b_e), .op1_dep_i(b_dep),
    .issue_vld_o(iv[0]), .issue_warp_o(iw[0]), .pair_o(pr[0]),
    .eng_a_o(ea[0]), .eng_b_o(eb[0]), .eng_fire_o(ef[0]));

  warp_issue_sched #(.N_WARPS(N), .SINGLE_ISSUE(1'b1)) uut_si (
    .clk_i(clk), .rst_ni(rst_n), .slot_valid_i(v), .slot_ready_i(r),
    .op0_eng_i(a_e), .op1_vld_i(b_vld), .op1_eng_i(b_e), .op1_dep_i(b_dep),
    .issue_vld_o(iv[1]), .issue_warp_o(iw[1]), .pair_o(pr[1]),
    .eng_a_o(ea[1]), .eng_b_o(eb[1]), .eng_fire_o(ef[1]));

  int total = 0, bad = 0;
  int mptr [2];
  int mcnt [2][4];
  int last_fire [2][4];
  int cyc = 0;
  logic [31:0] seed = 32'h1234_5678;

  function automatic int ii_of(int e);
    return (e == 1 || e == 2) ? 4 : 1;
  endfunction

  function automatic logic [31:0] rnd();
    seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
    return seed;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s cyc=%0d actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  // compare outputs of instance k against the model, sampled before the edge
  task automatic eval(input int k);
    int ew, ee_a, ee_b, efire;
    bit evld, epair, skipped;
    evld = 0; epair = 0; ew = 0; skipped = 0; ee_a = 0; ee_b = 0;
    for (int i = 0; i < N; i++) begin
      int w;
      w = (mptr[k] + i) % N;
      if (!evld && v[w] && r[w]) begin
        if (mcnt[k][a_e[2*w +: 2]] == 0) begin evld = 1; ew = w; end
        else skipped = 1;
      end
    end
    if (evld) begin
      ee_a = a_e[2*ew +: 2];
      epair = (k == 0) && b_vld[ew] && !b_dep[ew] && (b_e[2*ew +: 2] != ee_a)
              && (mcnt[k][b_e[2*ew +: 2]] == 0);
      if (epair) ee_b = b_e[2*ew +: 2];
    end
    efire = 0;
    if (evld)  efire |= 1 << ee_a;
    if (epair) efire |= 1 << ee_b;
    chk(evld ? "R2" : "R3", int'(iv[k]), int'(evld));
    if (evld && iv[k]) begin
      chk(skipped ? "R7" : "R2", int'(iw[k]), ew);
      chk("R1", int'(v[iw[k]] & r[iw[k]]), 1);
      chk("R4", int'(ea[k]), ee_a);
    end
    chk(k == 1 ? "R8" : "R5", int'(pr[k]), int'(epair));
    chk("R9", int'(pr[k] & !iv[k]), 0);
    chk("R4", int'(ef[k]), efire);
    chk("R4", int'(eb[k]), ee_b);
    for (int e = 1; e <= 2; e++)
      if (ef[k][e]) chk("R6", int'(cyc - last_fire[k][e] >= 4), 1);
  endtask

  task automatic model_step(input int k);
    for (int e = 0; e < 4; e++) begin
      if (ef[k][e]) begin mcnt[k][e] = ii_of(e) - 1; last_fire[k][e] = cyc; end
      else if (mcnt[k][e] > 0) mcnt[k][e]--;
    end
    if (iv[k]) mptr[k] = (int'(iw[k]) + 1) % N;
  endtask

  task automatic cycle_run();
    #8;
    eval(0); eval(1);
    @(posedge clk);
    model_step(0); model_step(1);
    cyc++;
    @(negedge clk);
  endtask

  task automatic set_all(input logic [1:0] e0, input logic [1:0] e1, input logic bv, input logic dep);
    v = '1; r = '1; b_vld = {N{bv}}; b_dep = {N{dep}};
    for (int w = 0; w < N; w++) begin a_e[2*w +: 2] = e0; b_e[2*w +: 2] = e1; end
  endtask

  initial begin
    #(20 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    v = '0; r = '0; b_vld = '0; b_dep = '0; a_e = '0; b_e = '0;
    for (int k = 0; k < 2; k++) begin
      mptr[k] = 0;
      for (int e = 0; e < 4; e++) begin mcnt[k][e] = 0; last_fire[k][e] = -100; end
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state: nothing ready, nothing issues (R3)
    cycle_run();
    chk("R3", int'(iv[0]), 0);
    // all ALU, ready: warp 0 first after reset, then 1 (R2)
    set_all(2'd0, 2'd3, 1'b1, 1'b0);
    #8; chk("R2", int'(iw[0]), 0); chk("R5", int'(pr[0]), 1); chk("R8", int'(pr[1]), 0);
    @(negedge clk);
    cyc++;
    for (int k = 0; k < 2; k++) begin mptr[k] = 1; last_fire[k][0] = cyc - 1; end
    // second depends on first: no pair (R5)
    set_all(2'd0, 2'd3, 1'b1, 1'b1);
    cycle_run();
    // back-to-back SFU-first warps: one issue per 4 cycles (R6, R7)
    set_all(2'd1, 2'd0, 1'b1, 1'b0);
    repeat (8) cycle_run();
    // ld/st first, sfu second, plus same-engine pair refusal
    set_all(2'd2, 2'd2, 1'b1, 1'b0);
    repeat (6) cycle_run();
    set_all(2'd2, 2'd1, 1'b1, 1'b0);
    repeat (6) cycle_run();
    // pseudo-random sweep
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] x;
      x = rnd();
      v = rnd()[N-1:0] | rnd()[N-1:0];
      r = (n % 16 == 15) ? '0 : rnd()[N-1:0];
      a_e = x[2*N-1:0];
      b_e = rnd()[2*N-1:0];
      b_vld = rnd()[N-1:0];
      b_dep = rnd()[N-1:0] & rnd()[N-1:0];
      cycle_run();
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule